// File: doc/BRIEF.md
# Two-Domain Reset Sequencer

This block produces the two reset levels of a small microcontroller. The system reset clears every peripheral register and counter, and it always carries the processor reset with it. The processor reset on its own restarts only the core and leaves peripheral register contents as they were. An external active-low reset pin or a low-voltage detector flag starts a system reset. A watchdog overflow pulse starts a processor-only reset. The detector and the watchdog can each be switched off by a static enable.

When every cause has gone, both outputs stay asserted for a fixed number of cycles of the operating clock. A single counter measures this hold-off. Its length depends on which oscillator drives the core: 256 cycles for the slow one and 1024 for the fast one. The pin is brought through a two-stage synchronizer. Every reset level comes from a flop, so assertion by the pin is asynchronous and every release happens on a clock edge. A sticky flag records whether the last reset was a processor-only watchdog reset.

Top module: `dual_reset_ctrl`

## Requirements
- R1: A low level on `extRstN` drives `sysRstN`, `cpuRstN` and `wdtOnly` low at once, without waiting for a clock edge. After the pin rises, it is considered inactive from the second rising clock edge onward.
- R2: While `lvdEn` is 1, a high `lvdFlag` sampled at a clock edge asserts both `sysRstN` and `cpuRstN` (low). While `lvdEn` is 0, `lvdFlag` has no effect on any output.
- R3: Whenever `sysRstN` is low, `cpuRstN` is low as well.
- R4: While `wdtEn` is 1, a one-cycle `wdtOvf` pulse sampled at a clock edge drives `cpuRstN` low and leaves `sysRstN` high. While `wdtEn` is 0, `wdtOvf` has no effect.
- R5: Both outputs rise together on the N-th rising edge after the last edge at which any cause was present. N is 256 when the latched clock select is 0 (slow) and 1024 when it is 1 (fast). For a pin reset, this places the release at edge N+2 counted from the first edge after the pin rises.
- R6: `fastSel` is captured only on edges where a cause is present. Changing it while the hold-off counts has no effect on the length.
- R7: A new cause that arrives while the hold-off is counting restarts it from zero.
- R8: `wdtOnly` is set to 1 by a watchdog reset that begins outside a system reset. Only a system reset clears it. When a system cause and a watchdog pulse share a clock edge, the system reset wins and the flag ends at 0.
- R9: A watchdog pulse that arrives while a system reset is counting, including on its release edge, keeps both outputs low, restarts the count and leaves `wdtOnly` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock (the selected oscillator) |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| lvdFlag | input | 1 | Low-voltage detector output, active high |
| lvdEn | input | 1 | Static enable for the detector source |
| wdtOvf | input | 1 | Watchdog overflow pulse, one clock wide |
| wdtEn | input | 1 | Static enable for the watchdog source |
| fastSel | input | 1 | Operating clock select: 0 slow, 1 fast |
| sysRstN | output | 1 | System reset, active low |
| cpuRstN | output | 1 | Processor reset, active low |
| wdtOnly | output | 1 | Sticky: last reset was watchdog-only |

## Verification
Two functions can meet on one clock edge. A new reset cause can arrive on the edge where the hold-off would end, and a watchdog pulse can share an edge with a system cause. The bench provokes the first by counting cycles from a detector pulse and raising the watchdog pulse so that it is sampled exactly on the computed release edge. It judges the result by expecting both outputs to stay low and the release to move a full hold-off later. For the second, it raises the detector flag and the watchdog pulse together and expects a system reset with the sticky flag at 0.

// File: rtl/dual_rst_pkg.sv
package dual_rst_pkg;
  // Strobes from the sequencer to the delay datapath.
  typedef struct packed {
    logic cntClear;  // a cause is present: zero the counter, capture the clock select
    logic cntRun;    // reset held with no cause: advance the counter
  } rstStrobeT;
endpackage

// File: rtl/rst_delay_path.sv
module rst_delay_path
  import dual_rst_pkg::*;
#(
  parameter int SLOW_DIV    = 256,
  parameter int FAST_DIV    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      extRstN,
  input  logic      fastSel,
  input  rstStrobeT strobe,
  output logic      extAsserted,
  output logic      cntDone
);
  localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       cntLast;
  logic                   fastQ;

  // Pin synchronizer: cleared at once by the pin, refilled with ones edge by edge.
  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN) syncQ <= '0;
    else          syncQ <= {syncQ[SYNC_STAGES-2:0], 1'b1};
  end

  assign extAsserted = !syncQ[SYNC_STAGES-1];

  // Hold-off counter and captured clock select.
  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN) begin
      cnt   <= '0;
      fastQ <= 1'b0;
    end else if (strobe.cntClear) begin
      cnt   <= '0;
      fastQ <= fastSel;
    end else if (strobe.cntRun) begin
      cnt   <= cntDone ? '0 : cnt + 1'b1;
    end
  end

  assign cntLast = fastQ ? FAST_LAST : SLOW_LAST;
  assign cntDone = (cnt == cntLast);

  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!extRstN)
    cnt <= cntLast);

  assert_select_frozen_R6: assert property (@(posedge clk) disable iff (!extRstN)
    (strobe.cntRun && !strobe.cntClear) |=> $stable(fastQ));

  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!extRstN)
    strobe.cntClear |=> (cnt == '0));
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import dual_rst_pkg::*;
(
  input  logic      clk,
  input  logic      extRstN,
  input  logic      extAsserted,
  input  logic      lvdFlag,
  input  logic      lvdEn,
  input  logic      wdtOvf,
  input  logic      wdtEn,
  input  logic      cntDone,
  output rstStrobeT strobe,
  output logic      sysRstN,
  output logic      cpuRstN,
  output logic      wdtOnly
);
  logic sysAct;
  logic cpuAct;
  logic sysCause;
  logic wdtHit;

  assign sysCause = extAsserted | (lvdEn & lvdFlag);
  assign wdtHit   = wdtEn & wdtOvf;

  // Set/clear state: any cause sets, end of hold-off clears; causes take priority.
  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN) begin
      sysAct  <= 1'b1;
      cpuAct  <= 1'b1;
      wdtOnly <= 1'b0;
    end else if (sysCause) begin
      sysAct  <= 1'b1;
      cpuAct  <= 1'b1;
      wdtOnly <= 1'b0;
    end else if (wdtHit) begin
      cpuAct  <= 1'b1;
      if (!sysAct) wdtOnly <= 1'b1;
    end else if (cpuAct && cntDone) begin
      sysAct  <= 1'b0;
      cpuAct  <= 1'b0;
    end
  end

  assign strobe.cntClear = sysCause | wdtHit;
  assign strobe.cntRun   = cpuAct & ~(sysCause | wdtHit);
  assign sysRstN         = ~sysAct;
  assign cpuRstN         = ~cpuAct;

  assert_sys_carries_cpu_R3: assert property (@(posedge clk) disable iff (!extRstN)
    sysAct |-> cpuAct);

  assert_wdt_spares_io_R4: assert property (@(posedge clk) disable iff (!extRstN)
    (wdtHit && !sysCause && !sysAct) |=> (!sysAct && cpuAct));

  assert_release_on_count_R5: assert property (@(posedge clk) disable iff (!extRstN)
    $fell(cpuAct) |-> $past(cntDone));

  assert_flag_cleared_R8: assert property (@(posedge clk) disable iff (!extRstN)
    sysCause |=> !wdtOnly);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!extRstN)
    (wdtOnly && !sysCause) |=> wdtOnly);

  assert_wdt_in_sys_R9: assert property (@(posedge clk) disable iff (!extRstN)
    (wdtHit && sysAct) |=> (sysAct && !wdtOnly));
endmodule

// File: rtl/dual_reset_ctrl.sv
module dual_reset_ctrl
  import dual_rst_pkg::*;
#(
  parameter int SLOW_DIV    = 256,
  parameter int FAST_DIV    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic extRstN,
  input  logic lvdFlag,
  input  logic lvdEn,
  input  logic wdtOvf,
  input  logic wdtEn,
  input  logic fastSel,
  output logic sysRstN,
  output logic cpuRstN,
  output logic wdtOnly
);
  rstStrobeT strobeBus;
  logic      extAsserted;
  logic      cntDone;

  rst_delay_path #(
    .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) i_path (
    .clk(clk), .extRstN(extRstN), .fastSel(fastSel), .strobe(strobeBus),
    .extAsserted(extAsserted), .cntDone(cntDone)
  );

  rst_sequencer i_seq (
    .clk(clk), .extRstN(extRstN), .extAsserted(extAsserted),
    .lvdFlag(lvdFlag), .lvdEn(lvdEn), .wdtOvf(wdtOvf), .wdtEn(wdtEn),
    .cntDone(cntDone), .strobe(strobeBus),
    .sysRstN(sysRstN), .cpuRstN(cpuRstN), .wdtOnly(wdtOnly)
  );

  assert_cause_holds_cpu_R7: assert property (@(posedge clk) disable iff (!extRstN)
    strobeBus.cntClear |=> !cpuRstN);
endmodule

// File: tb/test_dual_reset_ctrl.sv
`timescale 1ns/1ps
module test_dual_reset_ctrl;
  localparam int SLOW = 256;
  localparam int FAST = 1024;

  logic clk = 1'b0;
  logic extRstN, lvdFlag, lvdEn, wdtOvf, wdtEn, fastSel;
  logic sysRstN, cpuRstN, wdtOnly;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int r3Viol = 0;
  int k;
  logic prevCpu = 1'b0;

  typedef struct { int relCyc; bit flag; string req; } expT;
  expT expQ[$];

  dual_reset_ctrl i_dual_reset_ctrl (
    .clk(clk), .extRstN(extRstN), .lvdFlag(lvdFlag), .lvdEn(lvdEn),
    .wdtOvf(wdtOvf), .wdtEn(wdtEn), .fastSel(fastSel),
    .sysRstN(sysRstN), .cpuRstN(cpuRstN), .wdtOnly(wdtOnly)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pushExp(input int relCyc, input bit flag, input string req);
    expT e;
    e.relCyc = relCyc; e.flag = flag; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: judges every release against the oldest expected item.
  always @(negedge clk) begin
    if (!sysRstN && cpuRstN) r3Viol++;
    if (cpuRstN && !prevCpu) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5", "unexpected release cycle", cyc, -1);
      end else begin
        expT e;
        e = expQ.pop_front();
        check(cyc == e.relCyc, e.req, "release cycle", cyc, e.relCyc);
        check(sysRstN == 1'b1, e.req, "sysRstN at release", sysRstN, 1);
        check(wdtOnly == e.flag, e.req, "wdtOnly after release", wdtOnly, e.flag);
      end
    end
    prevCpu = cpuRstN;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    extRstN = 1'b1; lvdFlag = 1'b0; lvdEn = 1'b0;
    wdtOvf = 1'b0; wdtEn = 1'b0; fastSel = 1'b0;
    #1 extRstN = 1'b0;
    #1;
    check(sysRstN == 1'b0, "R1", "reset sysRstN", sysRstN, 0);
    check(cpuRstN == 1'b0, "R1", "reset cpuRstN", cpuRstN, 0);
    check(wdtOnly == 1'b0, "R1", "reset wdtOnly", wdtOnly, 0);
    repeat (5) @(negedge clk);
    extRstN = 1'b1;
    pushExp(cyc + 2 + SLOW, 1'b0, "R1/R5 pin release");
    drain();

    // R4: watchdog-only reset
    wdtEn = 1'b1; lvdEn = 1'b1;
    @(negedge clk); wdtOvf = 1'b1; pushExp(cyc + 1 + SLOW, 1'b1, "R4/R8 watchdog");
    @(negedge clk); wdtOvf = 1'b0;
    check(sysRstN == 1'b1, "R4", "sysRstN during watchdog reset", sysRstN, 1);
    check(cpuRstN == 1'b0, "R4", "cpuRstN during watchdog reset", cpuRstN, 0);
    check(wdtOnly == 1'b1, "R8", "flag set by watchdog", wdtOnly, 1);
    drain();

    // R4: disabled watchdog ignored
    wdtEn = 1'b0;
    @(negedge clk); wdtOvf = 1'b1;
    @(negedge clk); wdtOvf = 1'b0;
    repeat (3) @(negedge clk);
    check(cpuRstN == 1'b1, "R4", "disabled watchdog cpuRstN", cpuRstN, 1);

    // R2: disabled detector ignored
    lvdEn = 1'b0; lvdFlag = 1'b1;
    repeat (5) @(negedge clk);
    check(sysRstN == 1'b1, "R2", "disabled detector sysRstN", sysRstN, 1);
    check(cpuRstN == 1'b1, "R2", "disabled detector cpuRstN", cpuRstN, 1);
    check(wdtOnly == 1'b1, "R2", "disabled detector keeps flag", wdtOnly, 1);
    lvdFlag = 1'b0;

    // R2/R5/R6: detector reset with fast clock, select changed mid-count
    lvdEn = 1'b1; fastSel = 1'b1;
    @(negedge clk); lvdFlag = 1'b1; pushExp(cyc + 1 + FAST, 1'b0, "R5/R6 fast hold-off");
    @(negedge clk); lvdFlag = 1'b0;
    check(sysRstN == 1'b0, "R2", "detector sysRstN", sysRstN, 0);
    check(cpuRstN == 1'b0, "R2", "detector cpuRstN", cpuRstN, 0);
    check(wdtOnly == 1'b0, "R8", "flag cleared by system reset", wdtOnly, 0);
    repeat (10) @(negedge clk);
    fastSel = 1'b0;
    drain();

    // R7: restart on a new cause during count
    wdtEn = 1'b1;
    @(negedge clk); wdtOvf = 1'b1;
    @(negedge clk); wdtOvf = 1'b0;
    repeat (100) @(negedge clk);
    wdtOvf = 1'b1; pushExp(cyc + 1 + SLOW, 1'b1, "R7 restart");
    @(negedge clk); wdtOvf = 1'b0;
    drain();

    // R8: system cause and watchdog on the same edge
    @(negedge clk); wdtOvf = 1'b1; lvdFlag = 1'b1;
    pushExp(cyc + 1 + SLOW, 1'b0, "R8 same edge");
    @(negedge clk); wdtOvf = 1'b0; lvdFlag = 1'b0;
    check(sysRstN == 1'b0, "R8", "same edge sysRstN", sysRstN, 0);
    check(wdtOnly == 1'b0, "R8", "same edge flag", wdtOnly, 0);
    drain();

    // R9: watchdog during system hold-off
    @(negedge clk); lvdFlag = 1'b1;
    @(negedge clk); lvdFlag = 1'b0;
    repeat (50) @(negedge clk);
    wdtOvf = 1'b1; pushExp(cyc + 1 + SLOW, 1'b0, "R9 watchdog in system reset");
    @(negedge clk); wdtOvf = 1'b0;
    check(sysRstN == 1'b0, "R9", "system reset kept", sysRstN, 0);
    check(wdtOnly == 1'b0, "R9", "flag stays clear", wdtOnly, 0);
    drain();

    // R9/R7: watchdog sampled on the release edge itself
    @(negedge clk); lvdFlag = 1'b1; k = cyc;
    @(negedge clk); lvdFlag = 1'b0;
    while (cyc != k + SLOW) @(negedge clk);
    wdtOvf = 1'b1; pushExp(cyc + 1 + SLOW, 1'b0, "R9 release-edge collision");
    @(negedge clk); wdtOvf = 1'b0;
    check(cpuRstN == 1'b0, "R9", "collision cpuRstN", cpuRstN, 0);
    check(sysRstN == 1'b0, "R9", "collision sysRstN", sysRstN, 0);
    drain();

    // R1: asynchronous assertion mid-cycle
    @(posedge clk); #1 extRstN = 1'b0;
    #0.5;
    check(sysRstN == 1'b0, "R1", "async sysRstN", sysRstN, 0);
    check(cpuRstN == 1'b0, "R1", "async cpuRstN", cpuRstN, 0);
    repeat (3) @(negedge clk);
    extRstN = 1'b1; pushExp(cyc + 2 + SLOW, 1'b0, "R1 pin release");
    drain();

    check(r3Viol == 0, "R3", "cycles with system reset but no cpu reset", r3Viol, 0);
    check(expQ.size() == 0, "R5", "pending expected releases", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule